// File: doc/BRIEF.md
# USB Suspend and Wake Controller

This block decides when a USB device drops into low-power suspend and how it climbs back out. It watches a decoded bus-activity strobe together with a bus-idle level. Once the bus has been quiet for longer than a configurable number of clock cycles, it parks the device. While parked it asserts an active-low sleep indication, asks the crystal oscillator to stop, and pulls an external RC settle node low so that its capacitor drains.

A resume event, a bus-reset event or a low level on the external reset input starts the wake sequence. The controller releases the RC node and keeps the internal logic clock-enable off. The node then recharges, and the clock-enable is restored only after the sensed level of that node has been seen high on two synchronised samples in a row. While the external reset input is held low, the device can never be suspended. No configuration state gates entry, so suspend can happen before enumeration finishes. The external reset input and the event strobes are taken as already synchronous to `clk`. The settle-node sense input is treated as asynchronous.

Top module: `usb_suspend_ctrl`

## Requirements
- R1: A cycle is quiet when `bus_act` is 0, `bus_idle` is 1 and `ext_rst_n` is 1. From the running state, the block enters suspend on the clock edge that samples the (TIMEOUT_CYC+1)th consecutive quiet cycle. After TIMEOUT_CYC quiet cycles it is still running.
- R2: A sampled `bus_act` of 1 or a `bus_idle` of 0 restarts the quiet count from zero. A run of exactly TIMEOUT_CYC quiet cycles followed by activity never causes suspend.
- R3: In suspend the outputs are `asleep_n`=0, `osc_stop`=1, `rc_pull_low`=1 and `clk_en`=0.
- R4: In suspend, a sampled `resume_evt`=1, `busrst_evt`=1 or `ext_rst_n`=0 moves the block to the wake-wait state on that edge. Wake-wait drives `rc_pull_low`=0, `osc_stop`=0, `clk_en`=0 and `asleep_n`=0.
- R5: While `ext_rst_n` is 0 the block never enters suspend, whatever the length of the quiet interval. Releasing it starts the quiet count from zero.
- R6: `rc_settled` passes through a two-flop synchronizer. Wake-wait returns to running on the second consecutive edge within wake-wait at which the synchronised value is 1. This is the fourth edge after `rc_settled` rises when that input stays high. Running drives `asleep_n`=1 and `clk_en`=1, and the quiet count restarts from zero.
- R7: In the running state, `resume_evt` and `busrst_evt` have no effect. In suspend, `bus_act` and `rc_settled` have no effect.
- R8: A synchronous active-high `rst` places the block in the running state with `asleep_n`=1, `osc_stop`=0, `rc_pull_low`=0 and `clk_en`=1, and clears the quiet count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_rst_n | input | 1 | External reset level, active low; blocks suspend and wakes the device |
| bus_act | input | 1 | One-cycle strobe for decoded bus activity such as a frame start |
| bus_idle | input | 1 | High while the bus lines are in the idle state |
| resume_evt | input | 1 | One-cycle strobe for a detected resume signal |
| busrst_evt | input | 1 | One-cycle strobe for a detected bus reset |
| rc_settled | input | 1 | Sensed level of the RC settle node, high when the oscillator is stable (asynchronous) |
| asleep_n | output | 1 | Active-low sleep indication |
| osc_stop | output | 1 | Request to stop the oscillator |
| rc_pull_low | output | 1 | Drive the RC settle node low |
| clk_en | output | 1 | Enable for the internal logic clock |

## Verification
The hardest point to reach from the ports is the exact edge of suspend entry. The one-cycle boundary between TIMEOUT_CYC and TIMEOUT_CYC+1 quiet cycles only shows if every quiet interval starts at a known edge. The stimulus therefore opens each interval with an activity pulse, a bus-idle release or an external-reset release, and probes the state both one cycle before and exactly at the expected entry edge. The wake path needs the settle input to be low through the whole of suspend. It also needs a single-cycle glitch inside wake-wait, to show that one high sample is not enough to restore the clock.

// File: rtl/usb_susp_pkg.sv
package usb_susp_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_SUSP = 2'd1,
    ST_WAKE = 2'd2
  } susp_state_t;
endpackage

// File: rtl/usb_susp_sync.sv
// Multi-flop synchronizer for a single asynchronous level (STAGES >= 2).
module usb_susp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/usb_susp_idle_timer.sv
// Saturating count of consecutive quiet cycles; expired once LIMIT is reached.
module usb_susp_idle_timer #(
  parameter int LIMIT = 144000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic quiet,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIMIT_V = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr || !quiet) cnt <= '0;
    else if (cnt != LIMIT_V)  cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIMIT_V);
endmodule

// File: rtl/usb_susp_fsm.sv
// Run / suspend / wake-wait sequencing with registered pin controls.
module usb_susp_fsm
  import usb_susp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        expired,
  input  logic        quiet,
  input  logic        wake_req,
  input  logic        stable_sync,
  output susp_state_t state,
  output logic        asleep_n,
  output logic        osc_stop,
  output logic        rc_pull_low,
  output logic        clk_en
);
  susp_state_t nxt;
  logic        seen_hi;
  logic        seen_nxt;

  always_comb begin
    nxt      = state;
    seen_nxt = 1'b0;
    unique case (state)
      ST_RUN:  if (expired && quiet) nxt = ST_SUSP;
      ST_SUSP: if (wake_req) nxt = ST_WAKE;
      ST_WAKE: begin
        seen_nxt = stable_sync;
        if (stable_sync && seen_hi) nxt = ST_RUN;
      end
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_RUN;
      seen_hi     <= 1'b0;
      asleep_n    <= 1'b1;
      osc_stop    <= 1'b0;
      rc_pull_low <= 1'b0;
      clk_en      <= 1'b1;
    end else begin
      state       <= nxt;
      seen_hi     <= seen_nxt;
      asleep_n    <= (nxt == ST_RUN);
      osc_stop    <= (nxt == ST_SUSP);
      rc_pull_low <= (nxt == ST_SUSP);
      clk_en      <= (nxt == ST_RUN);
    end
  end
endmodule

// File: rtl/usb_suspend_ctrl.sv
module usb_suspend_ctrl
  import usb_susp_pkg::*;
#(
  parameter int TIMEOUT_CYC = 144000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_rst_n,
  input  logic bus_act,
  input  logic bus_idle,
  input  logic resume_evt,
  input  logic busrst_evt,
  input  logic rc_settled,
  output logic asleep_n,
  output logic osc_stop,
  output logic rc_pull_low,
  output logic clk_en
);
  susp_state_t state;
  logic        quiet;
  logic        wake_req;
  logic        expired;
  logic        stable_sync;

  assign quiet    = bus_idle && !bus_act && ext_rst_n;
  assign wake_req = resume_evt || busrst_evt || !ext_rst_n;

  usb_susp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (rc_settled),
    .q   (stable_sync)
  );

  usb_susp_idle_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clr     (state != ST_RUN),
    .quiet   (quiet),
    .expired (expired)
  );

  usb_susp_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .expired     (expired),
    .quiet       (quiet),
    .wake_req    (wake_req),
    .stable_sync (stable_sync),
    .state       (state),
    .asleep_n    (asleep_n),
    .osc_stop    (osc_stop),
    .rc_pull_low (rc_pull_low),
    .clk_en      (clk_en)
  );
endmodule

// File: rtl/usb_suspend_ctrl_chk.sv
module usb_suspend_ctrl_chk #(
  parameter int LIMIT = 144000
) (
  input logic clk,
  input logic rst,
  input logic ext_rst_n,
  input logic bus_act,
  input logic bus_idle,
  input logic resume_evt,
  input logic busrst_evt,
  input logic rc_settled,
  input logic asleep_n,
  input logic osc_stop,
  input logic rc_pull_low,
  input logic clk_en
);
  // Consecutive quiet samples taken while running, observed from the ports.
  int qcnt;
  always_ff @(posedge clk) begin
    if (rst || !clk_en || !(bus_idle && !bus_act && ext_rst_n)) qcnt <= 0;
    else if (qcnt <= LIMIT + 1) qcnt <= qcnt + 1;
  end

  p_entry_count_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(osc_stop) |-> (qcnt == LIMIT + 1));

  p_activity_keeps_run_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_act && clk_en) |=> !osc_stop);

  p_susp_pins_r3: assert property (@(posedge clk) disable iff (rst)
    osc_stop |-> (!asleep_n && rc_pull_low && !clk_en));

  p_wake_release_r4: assert property (@(posedge clk) disable iff (rst)
    (osc_stop && (resume_evt || busrst_evt))
      |=> (!rc_pull_low && !osc_stop && !clk_en && !asleep_n));

  p_ext_hold_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(osc_stop) |-> $past(ext_rst_n));

  p_stable_before_clk_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_en) |-> ($past(rc_settled, 3) && $past(rc_settled, 4)));

  p_susp_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (osc_stop && !resume_evt && !busrst_evt && ext_rst_n) |=> osc_stop);
endmodule

bind usb_suspend_ctrl usb_suspend_ctrl_chk #(.LIMIT(TIMEOUT_CYC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ext_rst_n   (ext_rst_n),
  .bus_act     (bus_act),
  .bus_idle    (bus_idle),
  .resume_evt  (resume_evt),
  .busrst_evt  (busrst_evt),
  .rc_settled  (rc_settled),
  .asleep_n    (asleep_n),
  .osc_stop    (osc_stop),
  .rc_pull_low (rc_pull_low),
  .clk_en      (clk_en)
);

// File: tb/usb_suspend_ctrl_bench.sv
`timescale 1ns/1ps
module usb_suspend_ctrl_bench;
  localparam int T = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_rst_n = 1'b1;
  logic bus_act = 1'b0;
  logic bus_idle = 1'b1;
  logic resume_evt = 1'b0;
  logic busrst_evt = 1'b0;
  logic rc_settled = 1'b1;
  logic asleep_n, osc_stop, rc_pull_low, clk_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  usb_suspend_ctrl #(.TIMEOUT_CYC(T)) u_usb_suspend_ctrl (
    .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .bus_act(bus_act),
    .bus_idle(bus_idle), .resume_evt(resume_evt), .busrst_evt(busrst_evt),
    .rc_settled(rc_settled), .asleep_n(asleep_n), .osc_stop(osc_stop),
    .rc_pull_low(rc_pull_low), .clk_en(clk_en)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Behavioural reference: 0 run, 1 suspend, 2 wake-wait.
  int m_st = 0;
  int m_run = 0;
  int m_hi = 0;
  bit m_s1 = 1'b0, m_s2 = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_run = 0; m_hi = 0; m_s1 = 1'b0; m_s2 = 1'b0;
    end else begin
      if (m_st == 0) begin
        if (bus_idle && !bus_act && ext_rst_n) begin
          m_run++;
          if (m_run > T) m_st = 1;
        end else m_run = 0;
      end else if (m_st == 1) begin
        if (resume_evt || busrst_evt || !ext_rst_n) begin m_st = 2; m_hi = 0; end
      end else begin
        if (m_s2) m_hi++; else m_hi = 0;
        if (m_hi >= 2) begin m_st = 0; m_run = 0; end
      end
      m_s2 = m_s1;
      m_s1 = rc_settled;
    end
  end

  // Every-cycle comparison against the reference.
  always @(negedge clk) begin
    if (!rst && !done) begin
      string tag;
      int exp_v, act_v;
      tag = (m_st == 1) ? "R3" : (m_st == 2) ? "R4" : "R6";
      exp_v = {28'd0, (m_st == 0), (m_st == 1), (m_st == 1), (m_st == 0)};
      act_v = {28'd0, asleep_n, osc_stop, rc_pull_low, clk_en};
      check(act_v == exp_v, tag, act_v, exp_v);
    end
  end

  task automatic pulse_act();
    bus_act = 1'b1; tick(1); bus_act = 1'b0;
  endtask

  initial begin
    tick(3);
    // R8: reset state
    check(asleep_n == 1 && osc_stop == 0 && rc_pull_low == 0 && clk_en == 1, "R8",
          {asleep_n, osc_stop, rc_pull_low, clk_en}, 4'b1001);
    rst = 1'b0;
    pulse_act();
    tick(T - 1);
    check(osc_stop == 0, "R1", osc_stop, 0);   // timeout minus one
    tick(1);
    check(osc_stop == 0, "R1", osc_stop, 0);   // exactly the timeout
    tick(1);
    check(osc_stop == 1, "R1", osc_stop, 1);   // timeout plus one
    check(!asleep_n && rc_pull_low && !clk_en, "R3",
          {asleep_n, osc_stop, rc_pull_low, clk_en}, 4'b0110);
    rc_settled = 1'b0;
    tick(2);
    // R7: activity and a high settle level do nothing while suspended
    pulse_act();
    rc_settled = 1'b1; tick(5); rc_settled = 1'b0; tick(2);
    check(osc_stop == 1 && clk_en == 0, "R7", osc_stop, 1);
    // R4: resume wakes
    resume_evt = 1'b1; tick(1); resume_evt = 1'b0;
    check(!rc_pull_low && !osc_stop && !clk_en && !asleep_n, "R4",
          {asleep_n, osc_stop, rc_pull_low, clk_en}, 4'b0000);
    tick(6);
    check(clk_en == 0, "R6", clk_en, 0);
    // R6: single-sample glitch is not enough
    rc_settled = 1'b1; tick(1); rc_settled = 1'b0; tick(6);
    check(clk_en == 0, "R6", clk_en, 0);
    rc_settled = 1'b1;
    tick(3);
    check(clk_en == 0, "R6", clk_en, 0);
    tick(1);
    check(clk_en == 1 && asleep_n == 1, "R6", clk_en, 1);
    // R7: events ignored while running
    resume_evt = 1'b1; busrst_evt = 1'b1; tick(1);
    resume_evt = 1'b0; busrst_evt = 1'b0; tick(1);
    check(clk_en == 1 && osc_stop == 0, "R7", osc_stop, 0);
    // R2: bus not idle holds off suspend
    bus_idle = 1'b0; tick(3 * T);
    check(osc_stop == 0, "R2", osc_stop, 0);
    bus_idle = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick(T);
      pulse_act();
    end
    check(osc_stop == 0, "R2", osc_stop, 0);
    // R5: held external reset blocks suspend
    ext_rst_n = 1'b0; tick(3 * T);
    check(osc_stop == 0 && clk_en == 1, "R5", osc_stop, 0);
    ext_rst_n = 1'b1;
    tick(T);
    check(osc_stop == 0, "R5", osc_stop, 0);
    tick(1);
    check(osc_stop == 1, "R5", osc_stop, 1);
    rc_settled = 1'b0; tick(3);
    // R4: external reset low wakes
    ext_rst_n = 1'b0; tick(1); ext_rst_n = 1'b1;
    check(!osc_stop && !rc_pull_low && !clk_en, "R4", osc_stop, 0);
    rc_settled = 1'b1; tick(4);
    check(clk_en == 1, "R6", clk_en, 1);
    tick(T + 1);
    check(osc_stop == 1, "R1", osc_stop, 1);
    rc_settled = 1'b0; tick(2);
    // R4: bus reset wakes
    busrst_evt = 1'b1; tick(1); busrst_evt = 1'b0;
    check(!osc_stop && !rc_pull_low && !clk_en && !asleep_n, "R4", osc_stop, 0);
    rc_settled = 1'b1; tick(6);
    check(clk_en == 1, "R6", clk_en, 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule